// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Control Writes

This block is a watchdog timer on a simple synchronous register bus. After a hardware reset, and after a soft reset, it runs with no action from software. If the 32-bit up-counter overflows, the block pulses a timeout output for one cycle and reloads the counter from a programmable load register.

Software can stop the timer only by writing a two-word key pair to a start/stop register. A second key pair starts it again. Writes to that register are posted. Each write takes effect a fixed number of cycles after the bus accepts it. A write-pending bit stays set for that whole interval, and software polls it between the two key words.

A soft-reset control bit clears the block back to its armed state. A reset-done status bit shows when the soft reset has finished. Reads return data one cycle after the request, together with a valid strobe.

Top module: `wdt_keyed_top`

## Requirements
- R1: After hardware reset the status register (offset 0x14) reads 3: bit 0 is reset-done and bit 1 is running. The pending register (offset 0x34) reads 0. The counter (offset 0x28) advances by one each cycle.
- R2: A write to the start/stop register (offset 0x48) sets bit 4 of the pending register for exactly 4 cycles. The written key, taken from bits 15:0, takes effect in the last of those cycles.
- R3: Applying 0xAAAA and then 0x5555 to the start/stop register clears the running bit. While the timer is stopped, the counter holds its value, and it also holds a value written to it through the bus.
- R4: The stop sequence is reset, and the timer keeps running, if a wrong key reaches the start/stop register between 0xAAAA and 0x5555. A fresh 0xAAAA starts the sequence over.
- R5: Applying 0xBBBB and then 0x4444 sets the running bit again, and the counter resumes from the value it held.
- R6: A start/stop write that arrives while the pending bit is set is dropped. It neither changes the key sequence nor the running state.
- R7: When the running counter passes 0xFFFFFFFF, timeout is high for exactly one cycle and the counter continues from the load register (offset 0x2C).
- R8: The counter and load registers can be written and read back through the bus.
- R9: Writing 1 to bit 0 of the control register (offset 0x10) starts an 8-cycle soft reset, during which:
  - reset-done reads 0;
  - writes are ignored;
  - afterwards the block is running, with the load register and counter at their reset values.
- R10: While the timer is stopped, timeout never rises, even when the counter sits just below overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | High for one cycle, one cycle after busRe |
| timeout | output | 1 | One-cycle pulse on counter overflow |

## Verification
Several internal faults show up at the ports within a few reads:
- A key state machine stuck in the wrong state, or a wrong match, shows within one posted delay as a running bit that disagrees with the key pair written.
- A pending counter with the wrong length shows on the first back-to-back poll, because bit 4 reads wrong in the fourth or fifth read after the write.
- A counter that does not hold while stopped, or does not reload on overflow, shows in the next counter read or in the timeout pulse count tens of cycles later.
- A soft reset that leaves state behind shows as a nonzero load value once reset-done returns.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;     // soft reset in progress: clear datapath state
    logic cntEn;   // counter advances
    logic cntWr;   // bus write to counter
    logic loadWr;  // bus write to load register
  } dpStrobe_t;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_OFF1 = 2'd1,   // first stop word seen
    KEY_ON1  = 2'd2    // first start word seen
  } keyState_t;

  // Register byte offsets
  localparam int OFS_CTL  = 'h10;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_CNT  = 'h28;
  localparam int OFS_LOAD = 'h2C;
  localparam int OFS_PEND = 'h34;
  localparam int OFS_SS   = 'h48;

  localparam int PEND_BIT = 4;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int KEY_W    = 16,
  parameter int POST_DLY = 4,
  parameter int SRST_CYC = 8,
  parameter logic [KEY_W-1:0] KEY_OFF_A = 16'hAAAA,
  parameter logic [KEY_W-1:0] KEY_OFF_B = 16'h5555,
  parameter logic [KEY_W-1:0] KEY_ON_A  = 16'hBBBB,
  parameter logic [KEY_W-1:0] KEY_ON_B  = 16'h4444
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  wrKey,
  output dpStrobe_t         strobe,
  output logic              running,
  output logic              resetDone,
  output logic              pending
);

  localparam int PCNT_W = $clog2(POST_DLY + 1);
  localparam int SCNT_W = $clog2(SRST_CYC + 1);

  logic [SCNT_W-1:0] srstCnt;
  logic [PCNT_W-1:0] pendCnt;
  logic [KEY_W-1:0]  pendData;
  keyState_t         keyState;
  logic              enabled;

  logic srstAct, wrOk, ssHit, ctlHit, applyNow;

  assign srstAct  = (srstCnt != '0);
  assign wrOk     = busWe && !srstAct;
  assign ssHit    = wrOk && (busAddr == ADDR_W'(OFS_SS));
  assign ctlHit   = wrOk && (busAddr == ADDR_W'(OFS_CTL)) && wrKey[0];
  assign applyNow = (pendCnt == PCNT_W'(1));

  // Soft reset sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        srstCnt <= '0;
    else if (ctlHit)  srstCnt <= SCNT_W'(SRST_CYC);
    else if (srstAct) srstCnt <= srstCnt - 1'b1;
  end

  // Posted write tracking: accept only when nothing is pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt  <= '0;
      pendData <= '0;
    end else if (srstAct) begin
      pendCnt  <= '0;
    end else if (ssHit && pendCnt == '0) begin
      pendCnt  <= PCNT_W'(POST_DLY);
      pendData <= wrKey;
    end else if (pendCnt != '0) begin
      pendCnt  <= pendCnt - 1'b1;
    end
  end

  // Key sequence on applied values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyState <= KEY_IDLE;
      enabled  <= 1'b1;
    end else if (srstAct) begin
      keyState <= KEY_IDLE;
      enabled  <= 1'b1;
    end else if (applyNow) begin
      keyState <= KEY_IDLE;
      if (pendData == KEY_OFF_A)      keyState <= KEY_OFF1;
      else if (pendData == KEY_ON_A)  keyState <= KEY_ON1;
      else if (pendData == KEY_OFF_B && keyState == KEY_OFF1) enabled <= 1'b0;
      else if (pendData == KEY_ON_B  && keyState == KEY_ON1)  enabled <= 1'b1;
    end
  end

  always_comb begin
    strobe.clr    = srstAct;
    strobe.cntEn  = enabled && !srstAct;
    strobe.cntWr  = wrOk && (busAddr == ADDR_W'(OFS_CNT));
    strobe.loadWr = wrOk && (busAddr == ADDR_W'(OFS_LOAD));
  end

  assign running   = enabled;
  assign resetDone = !srstAct;
  assign pending   = (pendCnt != '0);

  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (pendCnt != '0 && ssHit) |=> $stable(pendData)); // R6
  AST_STOP_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enabled) |-> $past(keyState) == KEY_OFF1); // R3
  AST_START_KEYED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enabled) && !$past(srstAct)) |-> $past(keyState) == KEY_ON1); // R5
  AST_SRST_REARM: assert property (@(posedge clk) disable iff (!rstN)
    srstAct |=> enabled); // R9

endmodule

// File: rtl/wdt_dp.sv
module wdt_dp
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] loadVal,
  output logic             timeout
);

  logic wrap;
  assign wrap = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      loadVal <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (strobe.clr) begin
        cnt     <= '0;
        loadVal <= '0;
      end else begin
        if (strobe.loadWr) loadVal <= wdata;
        if (strobe.cntWr) begin
          cnt <= wdata;
        end else if (strobe.cntEn) begin
          if (wrap) begin
            cnt     <= loadVal;
            timeout <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.cntEn && !strobe.cntWr && !strobe.clr) |=> $stable(cnt)); // R3
  AST_TMO_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> $past(strobe.cntEn)); // R10
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !$past(strobe.cntWr)) |-> cnt == $past(loadVal)); // R7

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int KEY_W    = 16,
  parameter int POST_DLY = 4,
  parameter int SRST_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              timeout
);

  dpStrobe_t         strobe;
  logic              running, resetDone, pending;
  logic [DATA_W-1:0] cnt, loadVal, rdMux;

  wdt_ctrl #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .POST_DLY(POST_DLY), .SRST_CYC(SRST_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .wrKey(busWdata[KEY_W-1:0]), .strobe(strobe), .running(running),
    .resetDone(resetDone), .pending(pending)
  );

  wdt_dp #(.CNT_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata),
    .cnt(cnt), .loadVal(loadVal), .timeout(timeout)
  );

  always_comb begin
    rdMux = '0;
    case (busAddr)
      ADDR_W'(OFS_STAT): begin
        rdMux[0] = resetDone;
        rdMux[1] = running;
      end
      ADDR_W'(OFS_CNT):  rdMux = cnt;
      ADDR_W'(OFS_LOAD): rdMux = loadVal;
      ADDR_W'(OFS_PEND): rdMux[PEND_BIT] = pending;
      default:           rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= busRe;
      if (busRe) busRdata <= rdMux;
    end
  end

endmodule

// File: tb/test_wdt_keyed_top.sv
module test_wdt_keyed_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid, timeout;

  int checks = 0, failures = 0;
  int tmoCnt = 0, tmoWide = 0;
  logic tmoPrev = 1'b0;
  bit   ended = 0;

  logic [31:0] expQ[$];
  bit          gtQ[$];
  string       tagQ[$];

  localparam logic [7:0] A_CTL = 8'h10, A_STAT = 8'h14, A_CNT = 8'h28,
                         A_LOAD = 8'h2C, A_PEND = 8'h34, A_SS = 8'h48;

  always #2 clk = ~clk;

  wdt_keyed_top i_wdt_keyed_top (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .timeout(timeout)
  );

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (busRvalid) begin
      if (expQ.size() == 0) begin
        chk(0, "unexpected read", busRdata, 0);
      end else begin
        logic [31:0] e;
        bit g;
        string t;
        e = expQ.pop_front();
        g = gtQ.pop_front();
        t = tagQ.pop_front();
        chk(g ? (busRdata > e) : (busRdata == e), t, busRdata, e);
      end
    end
    if (rstN && timeout) begin
      tmoCnt++;
      if (tmoPrev) tmoWide++;
    end
    tmoPrev = timeout;
  end

  // Drivers (entered at a falling edge)
  task automatic wr(logic [7:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, bit gt, string tag);
    expQ.push_back(e); gtQ.push_back(gt); tagQ.push_back(tag);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_STAT, 32'h3, 0, "R1 status");
    rd(A_PEND, 32'h0, 0, "R1 pending");
    rd(A_CNT, 32'h0, 1, "R1 counting");

    // R4 broken sequence keeps running
    wr(A_SS, 32'hAAAA); idle(5);
    wr(A_SS, 32'h1234); idle(5);
    wr(A_SS, 32'h5555); idle(5);
    rd(A_STAT, 32'h3, 0, "R4 still running");

    // R2 pending window: 4 reads high, then low
    wr(A_SS, 32'hAAAA);
    for (int i = 0; i < 4; i++) rd(A_PEND, 32'h10, 0, "R2 pending high");
    rd(A_PEND, 32'h0, 0, "R2 pending low");

    // R3 stop
    wr(A_SS, 32'h5555); idle(5);
    rd(A_STAT, 32'h1, 0, "R3 stopped");
    wr(A_CNT, 32'h1000); idle(10);
    rd(A_CNT, 32'h1000, 0, "R3 counter held");

    // R8 load register
    wr(A_LOAD, 32'h100);
    rd(A_LOAD, 32'h100, 0, "R8 load readback");

    // R5 restart resumes from held value
    wr(A_SS, 32'hBBBB); idle(5);
    wr(A_SS, 32'h4444); idle(5);
    rd(A_STAT, 32'h3, 0, "R5 running");
    rd(A_CNT, 32'h1000, 1, "R5 resumed");

    // R6 write during pending dropped
    wr(A_SS, 32'hAAAA);
    wr(A_SS, 32'h5555); idle(5);
    rd(A_STAT, 32'h3, 0, "R6 dropped write");
    wr(A_SS, 32'h5555); idle(5);
    rd(A_STAT, 32'h1, 0, "R6 sequence intact");

    // R10 no timeout while stopped
    wr(A_CNT, 32'hFFFF_FFF0); idle(40);
    chk(tmoCnt == 0, "R10 no timeout", tmoCnt, 0);
    rd(A_CNT, 32'hFFFF_FFF0, 0, "R10 counter held");

    // R7 overflow and reload
    wr(A_SS, 32'hBBBB); idle(5);
    wr(A_SS, 32'h4444); idle(30);
    chk(tmoCnt == 1, "R7 one timeout", tmoCnt, 1);
    chk(tmoWide == 0, "R7 pulse width", tmoWide, 0);
    rd(A_CNT, 32'hFF, 1, "R7 reloaded");

    // R9 soft reset
    wr(A_SS, 32'hAAAA); idle(5);
    wr(A_SS, 32'h5555); idle(5);
    rd(A_STAT, 32'h1, 0, "R9 stopped before");
    wr(A_CTL, 32'h1); idle(1);
    rd(A_STAT, 32'h2, 0, "R9 reset busy");
    wr(A_LOAD, 32'h55); idle(12);
    rd(A_STAT, 32'h3, 0, "R9 done and rearmed");
    rd(A_LOAD, 32'h0, 0, "R9 load cleared, write ignored");
    rd(A_CNT, 32'h0, 1, "R9 counting");

    idle(3);
    chk(expQ.size() == 0, "R1 reads answered", expQ.size(), 0);
    finishRun();
  end

endmodule